// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a byte-wide serial memory on a two-wire bus (SCL, SDA). A fast system clock oversamples both wires through a synchronizer. The block finds start and stop conditions on the sampled wires and answers an address byte whose upper nibble is the memory device type 1010. The three select bits in that byte must match the strap pins. For a write, the master then sends two word-address bytes and any number of data bytes. The data bytes go into a one-page buffer. A stop commits the buffer to the array during a simulated self-timed write interval. For the whole of that interval the block ignores the bus. A master can therefore poll the block's address until it is acknowledged again. Reads return bytes from an internal address pointer. A current-address read, a random read (address set by a dummy write and then a repeated start) and a sequential read all work this way. The pointer advances across the whole array and wraps at the top.

The array is a behavioural RAM of 2^ADDR_W bytes. With ADDR_W = 14 it holds 16K bytes in 512 pages of 32 bytes. The default build uses ADDR_W = 11 so that it elaborates quickly. The protection logic sits outside this block. It supplies a verdict, `wr_allow_i`, which is sampled at the stop, and the byte that a read of address FFFFh returns. SDA is driven only as an open-drain pull-down enable.

The controller has seven states:
- IDLE: waits for a start.
- DEVICE: receives the address byte. A match acknowledges and goes to ADDR_HI on a write or SEND on a read. A mismatch goes straight back to IDLE.
- ADDR_HI and ADDR_LO: each receives one word-address byte and acknowledges it. ADDR_HI steps to ADDR_LO, and ADDR_LO to WDATA.
- WDATA: takes data bytes until a stop or a start arrives. A stop with at least one buffered byte and the verdict set goes to BUSY; any other stop goes to IDLE.
- SEND: shifts out data. A master acknowledge loads the next byte; a not-acknowledge returns to IDLE.
- BUSY: counts WR_CYCLES clocks and then returns to IDLE.

A start seen in any state other than BUSY enters DEVICE.

Top module: `twsm_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) enters the address phase from any state except BUSY, even part-way through a byte. A stop (SDA rising while SCL is high) returns to idle. After reset SDA is released.
- R2: The address byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `sel_i[2:0]`. Bit 0 = 1 selects a read. On a mismatch SDA stays released in the ninth clock.
- R3: On a write, the two bytes after the address byte are acknowledged. They form a 16-bit word address (high byte first), and the pointer takes its low ADDR_W bits.
- R4: Each write data byte is acknowledged and stored at the pointer. Only the low 5 bits of the pointer then advance, wrapping inside the 32-byte page. Bytes beyond 32 overwrite earlier ones.
- R5: If a stop follows at least one data byte and `wr_allow_i` = 1, the block is busy for WR_CYCLES clocks. While busy it does not acknowledge its address and leaves SDA released. With `wr_allow_i` = 0 the data bytes are still acknowledged, but nothing is stored and no busy interval starts.
- R6: Each byte sent advances the pointer by one across the whole array, wrapping from 2^ADDR_W-1 to 0.
- R7: A master not-acknowledge after a byte ends the read, and SDA stays released on all later clocks until the next start.
- R8: A word address followed by a stop, with no data, only loads the pointer: no write interval starts. A repeated start after the word address gives a random read.
- R9: A current-address read returns the byte at the last accessed address plus one, after both reads and writes.
- R10: A read whose word address was FFFFh returns `prot_val_i`, and it leaves the pointer at 0.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock wire, asynchronous |
| sda_i | input | 1 | Serial data wire as seen on the bus, asynchronous |
| sel_i | input | 3 | Strap pins compared with address byte bits 3..1 |
| wr_allow_i | input | 1 | Write verdict from the protection logic, sampled at the stop |
| prot_val_i | input | 8 | Byte returned by a read of address FFFFh |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open-drain enable) |

## Verification
The bench covers the following corner cases; a design that got one wrong would misbehave as noted.
- Write starting four bytes before the end of a page: its last two bytes must land at bytes 0 and 1 of the same page. A design that carries into the page bits would place them in the next page.
- Write of 34 bytes: the first two bytes must be overwritten. This also checks that a current-address read then points at byte 2.
- Read starting at the top address: the next byte must come from address 0.
- Address polling: it must be refused just after a committed stop and accepted after the interval. After a refused verdict it must be accepted at once.
- Address followed only by a stop: it must not start an interval.
- Register read at FFFFh: it must reset the pointer.
- Further clocks after a not-acknowledge: a design that kept transmitting would pull SDA on them.
- Start in the middle of a byte: it must restart the transfer cleanly.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DEVICE, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA, ST_SEND, ST_BUSY
    } twsm_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twsm_sync.sv
module twsm_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_N-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_N-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_N-2:0], sda_in};
            scl_d  <= scl_lvl;
            sda_d  <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_sh[SYNC_N-1];
    assign sda_lvl   = sda_sh[SYNC_N-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twsm_store.sv
module twsm_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     buf_clr,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_in,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     copying
);
    localparam int PAGE_B = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [7:0]              mem  [DEPTH];
    logic [7:0]              pbuf [PAGE_B];
    logic [PAGE_B-1:0]       pval;
    logic [PAGE_W-1:0]       cidx;
    logic [ADDR_W-PAGE_W-1:0] cpage;
    logic                    last_copy;

    assign last_copy = copying && (cidx == PAGE_W'(PAGE_B - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copying <= 1'b0;
            cidx    <= '0;
            cpage   <= '0;
            pval    <= '0;
        end else begin
            if (commit) begin
                copying <= 1'b1;
                cidx    <= '0;
                cpage   <= page_in;
            end else if (copying) begin
                cidx <= cidx + 1'b1;
                if (last_copy) copying <= 1'b0;
            end
            if (buf_clr || last_copy) pval <= '0;
            else if (buf_we)          pval[buf_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_din;
        if (copying && pval[cidx]) mem[{cpage, cidx}] <= pbuf[cidx];
    end

    assign rd_data = mem[rd_addr];

    // R5: the page buffer is frozen while it is being copied
    p_frozen_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        copying |-> !buf_we);
    // R5: a commit never lands on a copy still in progress
    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !copying);
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 5,
    parameter int SYNC_N    = 2,
    parameter int WR_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    input  logic       wr_allow_i,
    input  logic [7:0] prot_val_i,
    output logic       sda_oe_o
);
    import twsm_pkg::*;

    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] WC_LAST = CNT_W'(WR_CYCLES - 1);

    twsm_state_t       state;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, addr_hi, rd_data;
    logic              in_ack, ack_go, mack, rw, reg_hit, wrote, copying;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  wcnt;
    logic [15:0]       waddr;
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic              rx_state, byte_in, buf_we, buf_clr, commit;

    twsm_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    twsm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(ptr[PAGE_W-1:0]),
        .buf_din(shreg), .buf_clr(buf_clr), .commit(commit),
        .page_in(ptr[ADDR_W-1:PAGE_W]), .rd_addr(ptr), .rd_data(rd_data),
        .copying(copying)
    );

    // outputs and strobes
    always_comb begin
        rx_state = (state == ST_DEVICE) || (state == ST_ADDR_HI) ||
                   (state == ST_ADDR_LO) || (state == ST_WDATA);
        byte_in  = rx_state && scl_fall && !in_ack && (bitcnt == 4'd8);
        buf_we   = byte_in && (state == ST_WDATA) && !reg_hit;
        buf_clr  = bus_start && (state != ST_BUSY);
        commit   = bus_stop && (state == ST_WDATA) && wrote && wr_allow_i;
        waddr    = {addr_hi, shreg};
        sda_oe_o = (in_ack && ack_go) ||
                   ((state == ST_SEND) && !in_ack && !shreg[7]);
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  addr_hi <= '0;
            in_ack <= 1'b0;    ack_go <= 1'b0; mack <= 1'b0; rw <= 1'b0;
            reg_hit <= 1'b0;   wrote <= 1'b0;  ptr <= '0;    wcnt <= '0;
        end else if (state == ST_BUSY) begin
            if (wcnt != WC_LAST) wcnt <= wcnt + 1'b1;
            else if (!copying) begin
                wcnt  <= '0;
                state <= ST_IDLE;
            end
        end else if (bus_start) begin
            state <= ST_DEVICE; bitcnt <= '0; in_ack <= 1'b0; ack_go <= 1'b0; wrote <= 1'b0;
        end else if (bus_stop) begin
            state <= commit ? ST_BUSY : ST_IDLE;
            bitcnt <= '0; in_ack <= 1'b0; ack_go <= 1'b0; wrote <= 1'b0;
        end else if (rx_state) begin
            if (scl_rise && !in_ack && bitcnt != 4'd8) begin
                shreg  <= {shreg[6:0], sda_lvl};
                bitcnt <= bitcnt + 1'b1;
            end else if (byte_in) begin
                in_ack <= 1'b1;
                ack_go <= 1'b1;
                case (state)
                    ST_DEVICE: if (shreg[7:1] != {DEV_TYPE, sel_i}) begin
                                   state <= ST_IDLE; in_ack <= 1'b0; ack_go <= 1'b0;
                               end else rw <= shreg[0];
                    ST_ADDR_HI: addr_hi <= shreg;
                    ST_ADDR_LO: begin
                                    ptr     <= waddr[ADDR_W-1:0];
                                    reg_hit <= &waddr;
                                end
                    default:    if (!reg_hit) begin
                                    wrote <= 1'b1;
                                    ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                                end
                endcase
            end else if (scl_fall && in_ack) begin
                in_ack <= 1'b0; ack_go <= 1'b0; bitcnt <= '0;
                case (state)
                    ST_DEVICE:  if (rw) begin
                                    state <= ST_SEND;
                                    shreg <= reg_hit ? prot_val_i : rd_data;
                                    ptr   <= reg_hit ? '0 : ptr + 1'b1;
                                    reg_hit <= 1'b0;
                                end else state <= ST_ADDR_HI;
                    ST_ADDR_HI: state <= ST_ADDR_LO;
                    ST_ADDR_LO: state <= ST_WDATA;
                    default:    state <= ST_WDATA;
                endcase
            end
        end else if (state == ST_SEND) begin
            if (scl_rise) begin
                if (in_ack) mack <= ~sda_lvl;
                else        bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
                if (in_ack) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    if (mack) begin
                        shreg   <= reg_hit ? prot_val_i : rd_data;
                        ptr     <= reg_hit ? '0 : ptr + 1'b1;
                        reg_hit <= 1'b0;
                    end else state <= ST_IDLE;
                end else if (bitcnt == 4'd8) in_ack <= 1'b1;
                else shreg <= {shreg[6:0], 1'b0};
            end
        end
    end

    // R5: nothing is driven during the write interval
    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> !sda_oe_o);
    // R5: interval counter stays within its limit
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (wcnt <= WC_LAST));
    // R11: drive changes only while the sampled clock is low
    p_drive_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl);
    // R4: page bits hold while data bytes arrive
    p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WDATA) && $past(state == ST_WDATA))
        |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
    // R3: bit counter never passes the ack slot
    p_bitcnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);
endmodule

// File: tb/sim_twsm_slave.sv
module sim_twsm_slave;
    localparam int AW  = 11;
    localparam int WRC = 600;
    localparam int Q   = 8;
    localparam logic [7:0] DW = 8'hAA;
    localparam logic [7:0] DR = 8'hAB;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, allow = 1'b1;
    logic [2:0] sel = 3'b101;
    logic [7:0] prot = 8'h9C;
    wire oe;
    wire sda_bus = sda_m & ~oe;

    twsm_slave #(.ADDR_W(AW), .PAGE_W(5), .SYNC_N(2), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_i(sel),
        .wr_allow_i(allow), .prot_val_i(prot), .sda_oe_o(oe)
    );

    int n_run = 0, n_fail = 0, bad_edges = 0;
    logic oe_prev = 1'b0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n && scl && (oe !== oe_prev)) bad_edges++;
        oe_prev <= oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic b_start();
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic tx(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        end
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = ~sda_bus; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic rx(input logic mack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = {b[6:0], sda_bus}; wt(Q); scl = 1'b0; wt(Q);
        end
        sda_m = ~mack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; sda_m = 1'b1; wt(Q);
    endtask

    task automatic set_addr(input logic [15:0] a, input string tag);
        logic k0, k1, k2;
        b_start(); tx(DW, k0); tx(a[15:8], k1); tx(a[7:0], k2);
        chk(k0 & k1 & k2, tag, {13'd0, k0, k1, k2}, 16'h7);
    endtask

    task automatic write_run(input logic [15:0] a, input int n, input logic [7:0] seed);
        logic k;
        set_addr(a, "R3 address acks");
        for (int i = 0; i < n; i++) begin
            tx(seed + 8'(i), k);
            chk(k, "R4 data ack", {15'd0, k}, 16'h1);
        end
        b_stop();
    endtask

    task automatic open_read(input logic [15:0] a);
        logic k;
        set_addr(a, "R8 dummy write acks");
        b_start(); tx(DR, k);
        chk(k, "R8 repeated-start read ack", {15'd0, k}, 16'h1);
    endtask

    task automatic get(input logic mack, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        rx(mack, b);
        chk(b == exp, tag, {8'd0, b}, {8'd0, exp});
    endtask

    task automatic poll(input logic exp, input string tag);
        logic k;
        b_start(); tx(DW, k); b_stop();
        chk(k == exp, tag, {15'd0, k}, {15'd0, exp});
    endtask

    task automatic t_reset();
        chk(oe == 1'b0, "R1 released after reset", {15'd0, oe}, 16'h0);
    endtask

    task automatic t_mismatch();
        logic k;
        b_start(); tx(8'hA8, k); b_stop();
        chk(!k, "R2 select mismatch nack", {15'd0, k}, 16'h0);
        b_start(); tx(8'hBA, k); b_stop();
        chk(!k, "R2 type mismatch nack", {15'd0, k}, 16'h0);
        poll(1'b1, "R2 match ack");
    endtask

    task automatic t_page_wrap();
        write_run(16'h007C, 6, 8'h40);
        poll(1'b0, "R5 busy after commit");
        wt(WRC + 100);
        poll(1'b1, "R5 ready after interval");
        open_read(16'h007C);
        get(1'b1, 8'h40, "R6 seq 0"); get(1'b1, 8'h41, "R6 seq 1");
        get(1'b1, 8'h42, "R6 seq 2"); get(1'b0, 8'h43, "R6 seq 3");
        b_stop();
        open_read(16'h0060);
        get(1'b1, 8'h44, "R4 in-page wrap 0"); get(1'b0, 8'h45, "R4 in-page wrap 1");
        b_stop();
    endtask

    task automatic t_overwrite();
        logic k;
        write_run(16'h00A0, 34, 8'h10);
        wt(WRC + 100);
        b_start(); tx(DR, k);
        chk(k, "R9 current read ack", {15'd0, k}, 16'h1);
        get(1'b0, 8'h12, "R9 current after write");
        b_stop();
        open_read(16'h00A0);
        get(1'b1, 8'h30, "R4 overwrite 0"); get(1'b1, 8'h31, "R4 overwrite 1");
        get(1'b0, 8'h12, "R4 kept 2");
        b_stop();
    endtask

    task automatic t_blocked();
        allow = 1'b0;
        write_run(16'h00A0, 1, 8'hEE);
        poll(1'b1, "R5 no interval when refused");
        allow = 1'b1;
        open_read(16'h00A0);
        get(1'b0, 8'h30, "R5 refused write not stored");
        b_stop();
    endtask

    task automatic t_top_wrap();
        logic any_oe = 1'b0;
        write_run(16'h07FF, 1, 8'h5A); wt(WRC + 100);
        write_run(16'h0000, 1, 8'hA5); wt(WRC + 100);
        open_read(16'h07FF);
        get(1'b1, 8'h5A, "R6 top byte"); get(1'b0, 8'hA5, "R6 wrap to zero");
        for (int i = 0; i < 9; i++) begin
            sda_m = 1'b1; wt(Q); scl = 1'b1; any_oe |= oe; wt(2*Q); any_oe |= oe;
            scl = 1'b0; wt(Q); any_oe |= oe;
        end
        chk(!any_oe, "R7 silent after nack", {15'd0, any_oe}, 16'h0);
        b_stop();
    endtask

    task automatic t_set_addr();
        logic k;
        set_addr(16'h0060, "R8 set address acks"); b_stop();
        poll(1'b1, "R8 no interval on address only");
        b_start(); tx(DR, k);
        get(1'b0, 8'h44, "R8 current read from set address");
        b_stop();
    endtask

    task automatic t_register();
        logic k;
        open_read(16'hFFFF);
        get(1'b0, 8'h9C, "R10 register byte");
        b_stop();
        b_start(); tx(DR, k);
        get(1'b0, 8'hA5, "R10 pointer back at zero");
        b_stop();
    endtask

    task automatic t_restart();
        logic k;
        set_addr(16'h007D, "R1 address before restart");
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        end
        b_start(); tx(DR, k);
        chk(k, "R1 restart mid-byte ack", {15'd0, k}, 16'h1);
        get(1'b0, 8'h41, "R1 read after restart");
        b_stop();
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(5);
        t_reset();
        t_mismatch();
        t_page_wrap();
        t_overwrite();
        t_blocked();
        t_top_wrap();
        t_set_addr();
        t_register();
        t_restart();
        chk(bad_edges == 0, "R11 drive changes only with SCL low", 16'(bad_edges), 16'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule